// File: doc/BRIEF.md
# Programmable Control-State Bug Matcher

This block watches a vector of critical control signals taken from a processor pipeline. It compares that vector with a small table of patch patterns. Each pattern is a value, a care-mask and a valid flag, and the table is written through a configuration port when the chip starts. When a valid pattern matches, the block asks the pipeline to flush. Once the flush is acknowledged, the block drives the core into a degraded mode in which instructions execute one at a time.

The block leaves degraded mode after a programmable number of instructions have retired. That number is never less than one. If the monitored state still matches after the core returns to full speed, the whole sequence starts again. This lets a known design flaw be bypassed in the field by loading new patterns, with no change to the silicon.

Top module: `ctl_bug_matcher`

## Requirements
- R1: After reset, `flush_req` and `degraded` are low, every table entry is invalid, and the hold count is 1.
- R2: In full-speed mode, suppose a valid entry satisfies ((mon_state ^ value) & mask) == 0 at a clock edge. Then `flush_req` is high after that edge. Bits where the mask is 0 do not matter.
- R3: An entry whose valid flag is 0 never causes a flush, even when its mask is all zeros.
- R4: `flush_req` stays high until `flush_done` is sampled high. At that edge it drops and `degraded` rises.
- R5: `degraded` stays high until the hold-count-th `retire` strobe. It then drops at the edge that samples that strobe.
- R6: A hold count written as 0 acts as 1, so a single retire ends degraded mode.
- R7: A pattern write (`cfg_we`) or a hold write (`hold_we`) has no effect unless the block is in full-speed mode.
- R8: While `flush_req` or `degraded` is high, a matching `mon_state` starts no new flush.
- R9: If the state still matches in the first full-speed cycle after degraded mode ends, `flush_req` rises again at the next edge.
- R10: `retire` and `flush_done` have no effect in full-speed mode.
- R11: `flush_req` and `degraded` are never high at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write one pattern entry |
| cfg_idx | input | IDX_W | Entry index for the write |
| cfg_value | input | STATE_W | Pattern value |
| cfg_mask | input | STATE_W | Care mask (1 = compared) |
| cfg_valid | input | 1 | Valid flag of the written entry |
| hold_we | input | 1 | Write the hold count |
| hold_val | input | CNT_W | Number of retires to stay degraded |
| mon_state | input | STATE_W | Monitored control-state vector |
| retire | input | 1 | One instruction retired |
| flush_done | input | 1 | Pipeline flush completed |
| flush_req | output | 1 | Flush request to the pipeline |
| degraded | output | 1 | Core must run one instruction at a time |

## Verification
Every result is due one edge after the inputs that cause it. A match seen at an edge raises `flush_req` after that edge. `flush_done` and the final `retire` move the mode outputs at the edge that samples them. A table or hold write first counts at the edge after it is stored.

The bench drives inputs at the falling edge and applies each vector across exactly one rising edge. It compares both outputs 1 ns after that edge, against a bench model that has been advanced by the same single step.

// File: rtl/bm_pkg.sv
package bm_pkg;
    typedef enum logic [1:0] {
        MODE_NORMAL   = 2'd0,
        MODE_FLUSH    = 2'd1,
        MODE_DEGRADED = 2'd2
    } mode_e;
endpackage

// File: rtl/bm_pattern_table.sv
module bm_pattern_table #(
    parameter int ENTRIES = 8,
    parameter int STATE_W = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [STATE_W-1:0] wr_value,
    input  logic [STATE_W-1:0] wr_mask,
    input  logic               wr_valid,
    input  logic [STATE_W-1:0] probe,
    output logic               hit
);
    typedef struct packed {
        logic [ENTRIES-1:0]              vld;
        logic [ENTRIES-1:0][STATE_W-1:0] val;
        logic [ENTRIES-1:0][STATE_W-1:0] msk;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic [ENTRIES-1:0] ent_hit;

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en && (int'(wr_idx) < ENTRIES)) begin
            tbl_d.vld[wr_idx] = wr_valid;
            tbl_d.val[wr_idx] = wr_value;
            tbl_d.msk[wr_idx] = wr_mask;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign ent_hit[e] = tbl_q.vld[e] &&
                            (((probe ^ tbl_q.val[e]) & tbl_q.msk[e]) == '0);
    end

    assign hit = |ent_hit;

    // R7: the stored table only changes on an accepted write
    a_r7_table_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(tbl_q));
    // R3: a hit needs at least one valid entry
    a_r3_invalid_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_q.vld == '0) |-> !hit);
endmodule

// File: rtl/bm_mode_seq.sv
module bm_mode_seq
    import bm_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             flush_done,
    input  logic             retire,
    input  logic             hold_we,
    input  logic [CNT_W-1:0] hold_val,
    output logic             flush_req,
    output logic             degraded,
    output logic             accept_cfg
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        mode_e            mode;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hold;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.mode)
            MODE_NORMAL: begin
                if (hold_we) seq_d.hold = hold_val;
                if (hit)     seq_d.mode = MODE_FLUSH;
            end
            MODE_FLUSH: begin
                if (flush_done) begin
                    seq_d.mode = MODE_DEGRADED;
                    seq_d.cnt  = (seq_q.hold == '0) ? ONE : seq_q.hold;
                end
            end
            MODE_DEGRADED: begin
                if (retire) begin
                    if (seq_q.cnt <= ONE) begin
                        seq_d.mode = MODE_NORMAL;
                        seq_d.cnt  = '0;
                    end else begin
                        seq_d.cnt = seq_q.cnt - ONE;
                    end
                end
            end
            default: seq_d.mode = MODE_NORMAL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.mode <= MODE_NORMAL;
            seq_q.cnt  <= '0;
            seq_q.hold <= ONE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign flush_req  = (seq_q.mode == MODE_FLUSH);
    assign degraded   = (seq_q.mode == MODE_DEGRADED);
    assign accept_cfg = (seq_q.mode == MODE_NORMAL);

    a_r4_flush_held: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && !flush_done) |=> flush_req);
    a_r4_enter_degraded: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_req && flush_done) |=> (degraded && !flush_req));
    a_r5_no_early_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (degraded && !retire) |=> degraded);
    a_r6_count_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(degraded) |-> (seq_q.cnt != '0));
    a_r8_no_reflush: assert property (@(posedge clk) disable iff (!rst_n)
        degraded |=> !flush_req);
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flush_req, degraded}));
endmodule

// File: rtl/ctl_bug_matcher.sv
module ctl_bug_matcher #(
    parameter int ENTRIES = 8,
    parameter int STATE_W = 16,
    parameter int CNT_W   = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [STATE_W-1:0] cfg_value,
    input  logic [STATE_W-1:0] cfg_mask,
    input  logic               cfg_valid,
    input  logic               hold_we,
    input  logic [CNT_W-1:0]   hold_val,
    input  logic [STATE_W-1:0] mon_state,
    input  logic               retire,
    input  logic               flush_done,
    output logic               flush_req,
    output logic               degraded
);
    logic accept_cfg;
    logic tbl_hit;

    bm_pattern_table #(
        .ENTRIES (ENTRIES),
        .STATE_W (STATE_W)
    ) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we && accept_cfg),
        .wr_idx   (cfg_idx),
        .wr_value (cfg_value),
        .wr_mask  (cfg_mask),
        .wr_valid (cfg_valid),
        .probe    (mon_state),
        .hit      (tbl_hit)
    );

    bm_mode_seq #(
        .CNT_W (CNT_W)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (tbl_hit),
        .flush_done (flush_done),
        .retire     (retire),
        .hold_we    (hold_we && accept_cfg),
        .hold_val   (hold_val),
        .flush_req  (flush_req),
        .degraded   (degraded),
        .accept_cfg (accept_cfg)
    );

    // R2: a hit in full-speed mode raises the flush request at the next edge
    a_r2_hit_flushes: assert property (@(posedge clk) disable iff (!rst_n)
        (tbl_hit && !flush_req && !degraded) |=> flush_req);
    // R10: retire strobes do not leave full-speed mode
    a_r10_retire_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_req && !degraded && !tbl_hit) |=> !degraded);
endmodule

// File: tb/ctl_bug_matcher_tb_top.sv
module ctl_bug_matcher_tb_top;
    localparam int ENTRIES = 8;
    localparam int STATE_W = 16;
    localparam int CNT_W   = 8;
    localparam int IDX_W   = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cfg_we = 1'b0;
    logic [IDX_W-1:0]   cfg_idx = '0;
    logic [STATE_W-1:0] cfg_value = '0;
    logic [STATE_W-1:0] cfg_mask = '0;
    logic               cfg_valid = 1'b0;
    logic               hold_we = 1'b0;
    logic [CNT_W-1:0]   hold_val = '0;
    logic [STATE_W-1:0] mon_state = '0;
    logic               retire = 1'b0;
    logic               flush_done = 1'b0;
    logic               flush_req;
    logic               degraded;

    always #2 clk = ~clk;

    ctl_bug_matcher #(
        .ENTRIES (ENTRIES),
        .STATE_W (STATE_W),
        .CNT_W   (CNT_W)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_value(cfg_value), .cfg_mask(cfg_mask), .cfg_valid(cfg_valid),
        .hold_we(hold_we), .hold_val(hold_val), .mon_state(mon_state),
        .retire(retire), .flush_done(flush_done),
        .flush_req(flush_req), .degraded(degraded)
    );

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    // bench model: 0 full speed, 1 flushing, 2 degraded
    int                 m_mode = 0;
    int                 m_cnt  = 0;
    int                 m_hold = 1;
    logic [STATE_W-1:0] m_val [ENTRIES];
    logic [STATE_W-1:0] m_msk [ENTRIES];
    bit                 m_vld [ENTRIES];

    function automatic bit ref_match(input logic [STATE_W-1:0] s);
        bit r = 1'b0;
        for (int e = 0; e < ENTRIES; e++)
            if (m_vld[e] && (((s ^ m_val[e]) & m_msk[e]) == '0)) r = 1'b1;
        return r;
    endfunction

    task automatic check(input string tag, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_update();
        bit hit_now = ref_match(mon_state);
        case (m_mode)
            0: begin
                if (cfg_we) begin
                    m_val[cfg_idx] = cfg_value;
                    m_msk[cfg_idx] = cfg_mask;
                    m_vld[cfg_idx] = cfg_valid;
                end
                if (hold_we) m_hold = int'(hold_val);
                if (hit_now) m_mode = 1;
            end
            1: if (flush_done) begin
                m_mode = 2;
                m_cnt  = (m_hold == 0) ? 1 : m_hold;
            end
            default: if (retire) begin
                if (m_cnt <= 1) m_mode = 0;
                else m_cnt--;
            end
        endcase
    endtask

    // inputs are set at the falling edge; one rising edge; compare 1 ns later
    task automatic step(input string tag);
        @(posedge clk);
        model_update();
        #1;
        check(tag, flush_req, (m_mode == 1), "flush_req");
        check(tag, degraded,  (m_mode == 2), "degraded");
        @(negedge clk);
        cfg_we = 1'b0; hold_we = 1'b0; retire = 1'b0; flush_done = 1'b0;
    endtask

    task automatic load(input int idx, input logic [STATE_W-1:0] v,
                        input logic [STATE_W-1:0] m, input bit vl, input string tag);
        cfg_we = 1'b1; cfg_idx = IDX_W'(idx); cfg_value = v; cfg_mask = m; cfg_valid = vl;
        step(tag);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int e = 0; e < ENTRIES; e++) begin
            m_val[e] = '0; m_msk[e] = '0; m_vld[e] = 1'b0;
        end
        void'($urandom(32'd1729));
        #10;
        @(negedge clk);
        check("R1", flush_req, 1'b0, "flush_req in reset");
        check("R1", degraded,  1'b0, "degraded in reset");
        rst_n = 1'b1;
        mon_state = 16'h0000;
        step("R1");
        step("R1");
        // R3: invalid entry with an all-zero mask
        load(1, 16'h0000, 16'h0000, 1'b0, "R3");
        mon_state = 16'h5555;
        step("R3");
        step("R3");
        load(0, 16'h1234, 16'hFF00, 1'b1, "R2");
        hold_we = 1'b1; hold_val = 8'd3;
        step("R2");
        mon_state = 16'h5599;
        step("R2");
        // R2: masked bits differ, still a hit
        mon_state = 16'h12AB;
        step("R2");
        step("R4");
        // R7: write during flush is dropped
        load(2, 16'hAAAA, 16'hFFFF, 1'b1, "R7");
        hold_we = 1'b1; hold_val = 8'd0;
        step("R7");
        flush_done = 1'b1;
        step("R4");
        // R8: state still matches, no new flush while degraded
        step("R8");
        retire = 1'b1; step("R5");
        step("R5");
        retire = 1'b1; step("R5");
        retire = 1'b1; step("R5");
        // R9: still matching on return
        step("R9");
        flush_done = 1'b1; step("R9");
        mon_state = 16'h0000;
        retire = 1'b1; step("R9");
        retire = 1'b1; step("R9");
        retire = 1'b1; step("R9");
        // R7: dropped entry 2 must not match
        mon_state = 16'hAAAA;
        step("R7");
        step("R7");
        // R10: retire and flush_done in full-speed mode
        retire = 1'b1; flush_done = 1'b1;
        step("R10");
        step("R10");
        // R6: hold 0 behaves as 1
        hold_we = 1'b1; hold_val = 8'd0;
        step("R6");
        mon_state = 16'h12FF;
        step("R6");
        mon_state = 16'h0000;
        flush_done = 1'b1; step("R6");
        retire = 1'b1; step("R6");
        step("R6");

        for (int i = 0; i < 4000; i++) begin
            int pick = int'($urandom % ENTRIES);
            if ($urandom % 2 == 0)
                mon_state = (m_val[pick] & m_msk[pick]) | (STATE_W'($urandom) & ~m_msk[pick]);
            else
                mon_state = STATE_W'($urandom);
            if ($urandom % 100 < 4) begin
                cfg_we = 1'b1; cfg_idx = IDX_W'($urandom); cfg_value = STATE_W'($urandom);
                cfg_mask = STATE_W'($urandom) | STATE_W'($urandom); cfg_valid = ($urandom % 4) != 0;
            end
            if ($urandom % 100 < 3) begin
                hold_we = 1'b1; hold_val = CNT_W'($urandom % 4);
            end
            flush_done = ($urandom % 10) < 4;
            retire     = ($urandom % 10) < 4;
            step(m_mode == 0 ? "R2" : (m_mode == 1 ? "R4" : "R5"));
        end

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule